// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block gathers single-cycle event pulses from four line transceivers and condenses them into one shared, active-low, open-drain interrupt request. Each transceiver owns sixteen event groups of sixteen bits. Every group has a mask word. An unmasked event bit latches into that group's status word, and the status word clears itself when software reads it. Each non-empty status word lights one bit of the transceiver's sixteen-bit vector. A vector mask decides which groups may show in the vector. The request line is pulled low while any permitted vector bit is set.

Three controls gate the path in different ways. A per-transceiver interrupt-permit bit stops that transceiver from pulling the line, but its status and vector keep working. A per-transceiver live bit, when cleared, empties all of its status words and holds them empty. A global power-up hold input does the same for every transceiver and also forces the line released at once. Software reaches masks, status, vector and controls through a plain synchronous register port with a one-cycle read latency. The open-drain pin is modelled as an output enable plus a data output that is always zero.

Top module: `evt_irq_aggregator`

## Requirements
- R1: After reset every mask word and vector mask reads 0, every status word reads 0, every control word reads 3 (permit and live both set), and irq_oe_o is 0.
- R2: Event input bit `evt_i[(x*16+g)*16+b]` sets status bit b of group g of transceiver x only if mask bit b of that group is 1. Group g implements bits 0 to 15-(g mod 4). Higher bits always read 0.
- R3: Vector bit g of a transceiver reads 1 exactly when status word g is non-zero and vector-mask bit g is 1.
- R4: A read of a status word returns its value on reg_rdata_o in the cycle after reg_rd_i, and that word is cleared at the same clock edge.
- R5: When a read of a status word and an unmasked event on a bit of that word fall in the same cycle, the read returns the old value and the bit is set afterwards.
- R6: irq_oe_o is 1 exactly when pwr_hold_n is 1 and some transceiver with both permit and live set has a non-zero vector. irq_o is always 0.
- R7: With a transceiver's permit bit at 0, its status and vector still latch and clear on read, but it never raises irq_oe_o.
- R8: With a transceiver's live bit at 0, all of its status words become 0 at the next edge and stay 0. Its vector is 0 and its masks keep their values.
- R9: While pwr_hold_n is 0, irq_oe_o is 0 in the same cycle. All status words of every transceiver are cleared at the next edge and do not latch events. Masks keep their values.
- R10: Register address fields: bits [7:6] select the transceiver, and bits [5:4] select the kind (0 status, 1 mask, 2 vector/vector mask, 3 control). Bits [3:0] give the group. For kind 2, bit 0 set selects the vector mask, and bit 0 clear selects the read-only vector. Control bit 0 is permit and bit 1 is live. Writes to status or to the vector have no effect.
- R11: While software reads status words one at a time, irq_oe_o stays 1 as long as any permitted vector bit remains set. This includes bits set by events that arrive during the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_hold_n | input | 1 | Global power-up hold, active low |
| evt_i | input | 1024 | Event pulses, one bit per transceiver/group/bit |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after reg_rd_i |
| irq_oe_o | output | 1 | Request line output enable (1 = pull low) |
| irq_o | output | 1 | Request line data, constant 0 |

## Verification
Sparse random event words across all 64 groups are mixed with random mask, vector-mask and control writes and random reads. This shows whether masking, latching and clear-on-read stay consistent together across transceivers. Directed sequences separate the three gating controls from each other: permit off must leave status readable, live off must empty status but keep masks, and hold must drop the line in the same cycle. A read colliding with an event on the same word tells a correct "event wins" merge apart from a lost event. Reading several pending groups one by one shows whether the line is released too early.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned KIND_W = 2;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [KIND_W-1:0] {
    KIND_STAT = 2'd0,
    KIND_MASK = 2'd1,
    KIND_VEC  = 2'd2,
    KIND_CTL  = 2'd3
  } kind_e;

  typedef struct packed {
    logic live;
    logic irq_allow;
  } xctl_t;

  localparam xctl_t XCTL_RST = '{live: 1'b1, irq_allow: 1'b1};

  // Implemented bits of a group: top (grp mod 4) bits are absent.
  function automatic word_t impl_bits(input int unsigned grp);
    return word_t'({REG_W{1'b1}} >> (grp % 4));
  endfunction
endpackage

// File: rtl/evt_irq_stat.sv
module evt_irq_stat
  import evt_irq_pkg::*;
#(
  parameter word_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en_i,
  input  word_t evt_i,
  input  word_t mask_i,
  input  logic  rd_clr_i,
  output word_t stat_o
);
  word_t hit;
  word_t stat_q;

  assign hit = evt_i & mask_i & IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n)         stat_q <= '0;
    else if (!upd_en_i) stat_q <= '0;
    else                stat_q <= (rd_clr_i ? '0 : stat_q) | hit;
  end

  assign stat_o = stat_q;

  // R2: a newly set bit needs an unmasked event in the previous cycle
  a_r2_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i & mask_i)) == '0));

  // R4: a read with no colliding event leaves the word empty
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && rd_clr_i && ((evt_i & mask_i & IMPL) == '0)) |=> (stat_q == '0));

  // R5: an accepted event is never lost, even against a read
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && ((evt_i & mask_i & IMPL) != '0))
      |=> ((stat_q & $past(evt_i & mask_i & IMPL)) == $past(evt_i & mask_i & IMPL)));

  // R9: held words are empty one edge later
  a_r9_held_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en_i) |=> (stat_q == '0));
endmodule

// File: rtl/evt_irq_xcvr.sv
module evt_irq_xcvr
  import evt_irq_pkg::*;
#(
  parameter int unsigned NG = 16,
  parameter int unsigned GB = $clog2(NG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_n_i,
  input  logic [NG*REG_W-1:0] evt_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  kind_e             kind_i,
  input  logic [GB-1:0]     idx_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output logic              irq_req_o
);
  word_t         mask_q [NG];
  word_t         stat   [NG];
  logic [NG-1:0] vmask_q;
  logic [NG-1:0] vec;
  xctl_t         ctl_q;
  logic          upd_en;

  assign upd_en = hold_n_i & ctl_q.live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) mask_q[g] <= '0;
      vmask_q <= '0;
      ctl_q   <= XCTL_RST;
    end else if (sel_i && wr_i) begin
      unique case (kind_i)
        KIND_MASK: mask_q[idx_i] <= wdata_i;
        KIND_VEC:  if (idx_i[0]) vmask_q <= wdata_i[NG-1:0];
        KIND_CTL:  ctl_q <= xctl_t'(wdata_i[1:0]);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic rd_clr;
    assign rd_clr = sel_i && rd_i && (kind_i == KIND_STAT) && (idx_i == GB'(g));

    evt_irq_stat #(.IMPL(impl_bits(g))) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en_i (upd_en),
      .evt_i    (evt_i[g*REG_W +: REG_W]),
      .mask_i   (mask_q[g]),
      .rd_clr_i (rd_clr),
      .stat_o   (stat[g])
    );

    assign vec[g] = (|stat[g]) & vmask_q[g];
  end

  always_comb begin
    rdata_o = '0;
    unique case (kind_i)
      KIND_STAT: rdata_o = stat[idx_i];
      KIND_MASK: rdata_o = mask_q[idx_i];
      KIND_VEC:  if (idx_i[0]) rdata_o[NG-1:0] = vmask_q;
                 else          rdata_o[NG-1:0] = vec;
      KIND_CTL:  rdata_o[1:0] = ctl_q;
      default: ;
    endcase
  end

  assign irq_req_o = ctl_q.irq_allow & ctl_q.live & (|vec);

  // R8: a transceiver that is not live shows an empty vector one edge later
  a_r8_vec_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.live) |=> (vec == '0));
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_irq_pkg::*;
#(
  parameter  int unsigned NX = 4,
  parameter  int unsigned NG = 16,
  localparam int unsigned XB = $clog2(NX),
  localparam int unsigned GB = $clog2(NG),
  localparam int unsigned AW = XB + KIND_W + GB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_hold_n,
  input  logic [NX*NG*REG_W-1:0] evt_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic                   irq_oe_o,
  output logic                   irq_o
);
  logic [XB-1:0] x_idx;
  kind_e         kind;
  logic [GB-1:0] g_idx;
  word_t         rd_x [NX];
  logic [NX-1:0] sel;
  logic [NX-1:0] irq_req;
  word_t         rd_mux;
  word_t         rdata_q;

  assign x_idx = reg_addr_i[AW-1 -: XB];
  assign kind  = kind_e'(reg_addr_i[GB +: KIND_W]);
  assign g_idx = reg_addr_i[GB-1:0];

  for (genvar x = 0; x < NX; x++) begin : g_xcvr
    assign sel[x] = (x_idx == XB'(x));

    evt_irq_xcvr #(.NG(NG), .GB(GB)) u_xcvr (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_n_i  (pwr_hold_n),
      .evt_i     (evt_i[x*NG*REG_W +: NG*REG_W]),
      .sel_i     (sel[x]),
      .wr_i      (reg_wr_i),
      .rd_i      (reg_rd_i),
      .kind_i    (kind),
      .idx_i     (g_idx),
      .wdata_i   (reg_wdata_i),
      .rdata_o   (rd_x[x]),
      .irq_req_o (irq_req[x])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int x = 0; x < NX; x++) if (sel[x]) rd_mux = rd_mux | rd_x[x];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_oe_o    = pwr_hold_n & (|irq_req);
  assign irq_o       = 1'b0;
endmodule

// File: tb/evt_irq_aggregator_bench.sv
module evt_irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_n = 1'b1;
  logic [1023:0] evt = '0;
  logic [7:0]    addr = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          irq_oe;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_stat [4][16];
  logic [15:0] m_mask [4][16];
  logic [15:0] m_vmask [4];
  logic [1:0]  m_ctl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_aggregator u_evt_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pwr_hold_n(hold_n), .evt_i(evt),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_oe_o(irq_oe), .irq_o(irq_o)
  );

  function automatic logic [7:0] A(int x, int k, int g);
    return {x[1:0], k[1:0], g[3:0]};
  endfunction

  function automatic logic [15:0] impl(int g);
    return 16'hFFFF >> (g % 4);
  endfunction

  function automatic logic [15:0] vec_of(int x);
    logic [15:0] v = '0;
    for (int g = 0; g < 16; g++) v[g] = (m_stat[x][g] != 0) && m_vmask[x][g];
    return v;
  endfunction

  function automatic logic [15:0] mread(logic [7:0] a);
    int x = a[7:6];
    int g = a[3:0];
    case (a[5:4])
      2'd0: return m_stat[x][g];
      2'd1: return m_mask[x][g];
      2'd2: return a[0] ? m_vmask[x] : vec_of(x);
      default: return {14'b0, m_ctl[x]};
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int x = 0; x < 4; x++) if (m_ctl[x] == 2'b11 && vec_of(x) != 0) r = 1'b1;
    return r & hold_n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    logic [15:0] nstat [4][16];
    logic        did_rd = rd;
    logic [15:0] erd = '0;
    if (rd) erd = mread(addr);
    for (int x = 0; x < 4; x++)
      for (int g = 0; g < 16; g++) begin
        logic hitrd = rd && addr[7:6] == x[1:0] && addr[5:4] == 2'd0 && addr[3:0] == g[3:0];
        if (!hold_n || !m_ctl[x][1]) nstat[x][g] = '0;
        else nstat[x][g] = (hitrd ? 16'h0 : m_stat[x][g]) |
                           (evt[(x*16+g)*16 +: 16] & m_mask[x][g] & impl(g));
      end
    if (wr) begin
      case (addr[5:4])
        2'd1: m_mask[addr[7:6]][addr[3:0]] = wdata;
        2'd2: if (addr[0]) m_vmask[addr[7:6]] = wdata;
        2'd3: m_ctl[addr[7:6]] = wdata[1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    m_stat = nstat;
    @(negedge clk);
    if (did_rd) chk(tag, rdata, erd);
    chk("R6", irq_oe, exp_irq());
    chk("R6", irq_o, 1'b0);
  endtask

  task automatic do_wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick("R10");
    wr = 1'b0;
  endtask

  task automatic do_rd(logic [7:0] a, string tag);
    addr = a; rd = 1'b1;
    tick(tag);
    rd = 1'b0;
  endtask

  task automatic pulse(int x, int g, logic [15:0] bits);
    evt[(x*16+g)*16 +: 16] = bits;
    tick("R2");
    evt = '0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd24681357));
    for (int x = 0; x < 4; x++) begin
      m_vmask[x] = '0; m_ctl[x] = 2'b11;
      for (int g = 0; g < 16; g++) begin m_stat[x][g] = '0; m_mask[x][g] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", irq_oe, 1'b0);
    for (int x = 0; x < 4; x++) begin
      do_rd(A(x, 3, 0), "R1");
      chk("R1", rdata, 16'h0003);
      do_rd(A(x, 1, 5), "R1");
      do_rd(A(x, 2, 1), "R1");
      do_rd(A(x, 0, 9), "R1");
    end

    // R2 masked event ignored, then unmasked with unimplemented top bit
    pulse(0, 1, 16'hFFFF);
    do_rd(A(0, 0, 1), "R2");
    chk("R2", rdata, 16'h0000);
    do_wr(A(0, 1, 1), 16'hFFFF);
    do_wr(A(0, 2, 1), 16'hFFFF);
    pulse(0, 1, 16'hFFFF);
    chk("R6", irq_oe, 1'b1);
    do_rd(A(0, 2, 0), "R3");
    chk("R3", rdata, 16'h0002);
    do_rd(A(0, 0, 1), "R2");
    chk("R2", rdata, 16'h7FFF);
    do_rd(A(0, 0, 1), "R4");
    chk("R4", rdata, 16'h0000);

    // R5 collision of read and event
    pulse(0, 1, 16'h0001);
    addr = A(0, 0, 1); rd = 1'b1; evt[(0*16+1)*16 + 3] = 1'b1;
    tick("R5");
    rd = 1'b0; evt = '0;
    chk("R5", rdata, 16'h0001);
    do_rd(A(0, 0, 1), "R5");
    chk("R5", rdata, 16'h0008);

    // R7 permit off
    pulse(0, 1, 16'h0010);
    do_wr(A(0, 3, 0), 16'h0002);
    chk("R7", irq_oe, 1'b0);
    do_rd(A(0, 2, 0), "R7");
    chk("R7", rdata, 16'h0002);
    do_rd(A(0, 0, 1), "R7");
    chk("R7", rdata, 16'h0010);
    do_wr(A(0, 3, 0), 16'h0003);

    // R8 live off
    pulse(0, 1, 16'h0020);
    do_wr(A(0, 3, 0), 16'h0001);
    pulse(0, 1, 16'h0040);
    chk("R8", irq_oe, 1'b0);
    do_rd(A(0, 0, 1), "R8");
    chk("R8", rdata, 16'h0000);
    do_rd(A(0, 1, 1), "R8");
    chk("R8", rdata, 16'hFFFF);
    do_wr(A(0, 3, 0), 16'h0003);

    // R9 global hold
    pulse(0, 1, 16'h0100);
    chk("R9", irq_oe, 1'b1);
    hold_n = 1'b0;
    #1 chk("R9", irq_oe, 1'b0);
    pulse(0, 1, 16'h0200);
    do_rd(A(0, 0, 1), "R9");
    chk("R9", rdata, 16'h0000);
    do_rd(A(0, 1, 1), "R9");
    chk("R9", rdata, 16'hFFFF);
    hold_n = 1'b1;
    @(negedge clk);

    // R10 writes to status and vector ignored
    pulse(0, 1, 16'h0004);
    do_wr(A(0, 0, 1), 16'h0000);
    do_wr(A(0, 2, 0), 16'h0000);
    do_rd(A(0, 2, 1), "R10");
    chk("R10", rdata, 16'hFFFF);
    do_rd(A(0, 0, 1), "R10");
    chk("R10", rdata, 16'h0004);

    // R11 line held while reading one group at a time
    do_wr(A(2, 1, 2), 16'hFFFF);
    do_wr(A(2, 1, 5), 16'hFFFF);
    do_wr(A(2, 2, 1), 16'h0024);
    evt[(2*16+2)*16 +: 16] = 16'h0001;
    evt[(2*16+5)*16 +: 16] = 16'h0002;
    tick("R11");
    evt = '0;
    do_rd(A(2, 0, 2), "R11");
    chk("R11", irq_oe, 1'b1);
    evt[(2*16+2)*16 +: 16] = 16'h0008;
    do_rd(A(2, 0, 5), "R11");
    evt = '0;
    chk("R11", irq_oe, 1'b1);
    do_rd(A(2, 0, 2), "R11");
    chk("R11", irq_oe, 1'b0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      for (int w = 0; w < 64; w++)
        evt[w*16 +: 16] = ($urandom % 8 == 0) ? 16'($urandom) : 16'h0;
      hold_n = ($urandom % 64 != 0);
      addr = 8'($urandom);
      case ($urandom % 8)
        0, 1, 2: begin rd = 1'b1; tick("R4"); end
        3: begin
          wr = 1'b1;
          wdata = (addr[5:4] == 2'd3 && $urandom % 4 != 0) ? 16'h0003 : 16'($urandom);
          tick("R10");
        end
        default: tick("R2");
      endcase
      rd = 1'b0; wr = 1'b0; evt = '0; hold_n = 1'b1;
    end
    @(negedge clk);
    finish_up();
  end
endmodule